// File: doc/BRIEF.md
# Packet Command Task-File Controller

This block is the device-side register front end of a packet-command storage interface. A host reaches eight byte-wide task-file registers through a register port and moves 16-bit words through a separate data port. Writing the command register starts one of a small set of operations. The block can open a packet phase, return a fixed identification block, refuse the plain identify command, or accept a feature setting.

During a packet phase the host writes six data words, which form a 12-byte command. The block hands that command to a backend port as a single-cycle pulse and then waits. The backend fills a local result buffer and answers with a result length or an error flag. The block then publishes the transfer size in the byte-count registers, sets the status and interrupt-reason codes, and raises an interrupt. It streams the result out of the buffer as data-port reads. A result larger than the maximum burst is sent as several bursts, and each burst is announced with its own interrupt.

Register indices: 0 data (a byte-lane read returns 0x00), 1 error/feature, 2 interrupt reason, 3 tag, 4 byte count low, 5 byte count high, 6 drive select, 7 command (write) / status (read).

Top module: `pkt_taskfile_ctrl`

## Requirements
- R1: After reset the status register (index 7) reads 0x00, the error register (index 1) reads 0x01, byte count low (index 4) reads 0x14, byte count high (index 5) reads 0xEB, and `irq` is low.
- R2: Writing 0xA0 to index 7 sets status to 0x08 (data request) and interrupt reason (index 2) to 0x01 (command/data), and leaves `irq` unchanged.
- R3: After 0xA0, six data-port writes form the packet. `pktValid` pulses for exactly one cycle after the sixth write, with word k in `pktBytes[16k+15:16k]`, which places byte 2k in the low half. Status then reads 0x80 (busy) until the backend answers.
- R4: A backend answer of length 0 sets status to 0x40 (ready), interrupt reason to 0x03, the byte count to 0, and raises `irq`.
- R5: A nonzero backend length L sets the byte count to min(L, MaxBurst), status to 0x18 (data request plus service), and interrupt reason to 0x02 (IO), and raises `irq`. Data reads then return buffer words in order from buffer index 0. The buffer index wraps modulo BufWords.
- R6: When a burst drains and result bytes remain, the byte count is reloaded with the next burst size (at most MaxBurst), status is 0x18, and `irq` is raised again. A burst of b bytes takes ceil(b/2) reads.
- R7: The read of the final word of the final burst sets status to 0x00 and interrupt reason to 0x02, and raises `irq`.
- R8: A backend error answer sets status to 0x09 (data request plus check), error to 0x50, both byte-count bytes to 0x00, and raises `irq`.
- R9: Writing 0xEC to index 7 sets error to 0x04 (abort) and status to 0x01 (check), and raises `irq`.
- R10: Writing 0xEF to index 7 sets status to 0x00, raises `irq`, and discards pending data, so that a following data read returns 0x0000.
- R11: Writing 0xA1 to index 7 sets the byte count to 0x0200 and status to 0x08, and raises `irq`. It then supplies 256 words: word 0 is 0x8580, word 49 is 0x0600, and all other words are 0x0000.
- R12: Any byte-lane register read clears `irq` on the next cycle, unless the same cycle raises it.
- R13: A data read with no data pending returns 0x0000 and changes no register.
- R14: Writing any other command code to index 7 changes no register and does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Byte-lane register write strobe |
| regRd | input | 1 | Byte-lane register read strobe (clears interrupt) |
| regIdx | input | 3 | Task-file register index |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational on regIdx) |
| dataWr | input | 1 | Data-port word write strobe |
| dataRd | input | 1 | Data-port word read strobe (advances the stream) |
| dataWdata | input | 16 | Data-port write word |
| dataRdata | output | 16 | Current data-port read word, zero when nothing is pending |
| irq | output | 1 | Interrupt request to host |
| pktValid | output | 1 | One-cycle pulse: packet complete |
| pktBytes | output | 96 | The 12 packet bytes, byte n at [8n+7:8n] |
| beDone | input | 1 | Backend answer strobe |
| beErr | input | 1 | Backend answer is an error |
| beLen | input | LenW | Backend total result length in bytes |
| beWrEn | input | 1 | Backend buffer write enable |
| beWrAddr | input | clog2(BufWords) | Backend buffer write address |
| beWrData | input | 16 | Backend buffer write word |

## Verification
The bench runs a table of result lengths. The table holds zero, one word, an odd byte count, exactly one burst, and results that need two and three bursts. A design that splits at the wrong place would load a wrong byte count or return a word off by one. A design that forgets the interrupt between bursts would leave `irq` low after the bench has cleared it. The final-word handoff, the error answer, and the identify block's sparse content are checked at their exact cycles. The bench also checks that an unknown command and an idle data read disturb nothing, and that a feature write discards a half-read identify stream.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam logic [2:0] IdxData   = 3'd0;
  localparam logic [2:0] IdxErr    = 3'd1;
  localparam logic [2:0] IdxReason = 3'd2;
  localparam logic [2:0] IdxTag    = 3'd3;
  localparam logic [2:0] IdxCntLo  = 3'd4;
  localparam logic [2:0] IdxCntHi  = 3'd5;
  localparam logic [2:0] IdxDrive  = 3'd6;
  localparam logic [2:0] IdxCmd    = 3'd7;

  localparam logic [7:0] StBusy  = 8'h80;
  localparam logic [7:0] StReady = 8'h40;
  localparam logic [7:0] StServ  = 8'h10;
  localparam logic [7:0] StDrq   = 8'h08;
  localparam logic [7:0] StCheck = 8'h01;

  localparam logic [7:0] IrCmdData = 8'h01;
  localparam logic [7:0] IrIo      = 8'h02;

  localparam logic [7:0] CmdPacket   = 8'hA0;
  localparam logic [7:0] CmdPktIdent = 8'hA1;
  localparam logic [7:0] CmdAtaIdent = 8'hEC;
  localparam logic [7:0] CmdFeature  = 8'hEF;

  localparam logic [7:0] ErrAbort   = 8'h04;
  localparam logic [7:0] ErrIllegal = 8'h50;

  localparam int PktWords = 6;

  typedef enum logic [1:0] {SRC_NONE, SRC_BUF, SRC_IDENT} src_e;

  typedef struct packed {
    logic        ldStatus;
    logic [7:0]  status;
    logic        ldReason;
    logic [7:0]  reason;
    logic        ldErr;
    logic [7:0]  err;
    logic        ldCount;
    logic [15:0] count;
    logic        raiseIrq;
    logic        pktCapture;
    logic [2:0]  pktSlot;
    logic        pktFire;
  } strobe_t;
endpackage

// File: rtl/tf_ctrl.sv
module tf_ctrl
  import tf_pkg::*;
#(
  parameter int LenW     = 24,
  parameter int MaxBurst = 63488,
  parameter int PtrW     = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWr,
  input  logic [2:0]      regIdx,
  input  logic [7:0]      regWdata,
  input  logic            dataWr,
  input  logic            dataRd,
  input  logic            beDone,
  input  logic            beErr,
  input  logic [LenW-1:0] beLen,
  output strobe_t         st,
  output src_e            src,
  output logic [PtrW-1:0] rdPtr
);
  localparam logic [LenW-1:0] BurstCap = LenW'(MaxBurst);
  localparam logic [LenW-1:0] IdentLen = LenW'(512);
  localparam logic [2:0]      LastSlot = 3'(PktWords - 1);

  typedef enum logic [2:0] {S_IDLE, S_PKT, S_WAIT, S_XFER, S_IDENT} state_e;

  state_e          state, stateN;
  logic [2:0]      pktCnt, pktCntN;
  logic [LenW-1:0] left, leftN, remain, remainN, nb;
  logic [PtrW-1:0] rdPtrN;

  function automatic logic [LenW-1:0] capLen(input logic [LenW-1:0] n);
    return (n > BurstCap) ? BurstCap : n;
  endfunction

  logic cmdWr;
  assign cmdWr = regWr && (regIdx == IdxCmd);

  always_comb begin
    st      = '0;
    stateN  = state;
    pktCntN = pktCnt;
    leftN   = left;
    remainN = remain;
    rdPtrN  = rdPtr;
    nb      = '0;
    if (cmdWr) begin
      case (regWdata)
        CmdPacket: begin
          st.ldStatus = 1'b1; st.status = StDrq;
          st.ldReason = 1'b1; st.reason = IrCmdData;
          stateN = S_PKT; pktCntN = '0; leftN = '0; remainN = '0; rdPtrN = '0;
        end
        CmdPktIdent: begin
          st.ldStatus = 1'b1; st.status = StDrq;
          st.ldCount  = 1'b1; st.count  = 16'h0200;
          st.raiseIrq = 1'b1;
          stateN = S_IDENT; leftN = IdentLen; remainN = '0; rdPtrN = '0;
        end
        CmdAtaIdent: begin
          st.ldErr    = 1'b1; st.err    = ErrAbort;
          st.ldStatus = 1'b1; st.status = StCheck;
          st.raiseIrq = 1'b1;
          stateN = S_IDLE; leftN = '0; remainN = '0;
        end
        CmdFeature: begin
          st.ldStatus = 1'b1; st.status = 8'h00;
          st.raiseIrq = 1'b1;
          stateN = S_IDLE; leftN = '0; remainN = '0; rdPtrN = '0;
        end
        default: ;
      endcase
    end else begin
      case (state)
        S_PKT: if (dataWr) begin
          st.pktCapture = 1'b1;
          st.pktSlot    = pktCnt;
          pktCntN       = pktCnt + 3'd1;
          if (pktCnt == LastSlot) begin
            st.pktFire  = 1'b1;
            st.ldStatus = 1'b1; st.status = StBusy;
            stateN      = S_WAIT;
          end
        end
        S_WAIT: if (beDone) begin
          st.raiseIrq = 1'b1;
          st.ldCount  = 1'b1;
          if (beErr) begin
            st.ldStatus = 1'b1; st.status = StDrq | StCheck;
            st.ldErr    = 1'b1; st.err    = ErrIllegal;
            st.count    = 16'h0000;
            stateN      = S_IDLE;
          end else begin
            nb       = capLen(beLen);
            leftN    = nb;
            remainN  = beLen - nb;
            rdPtrN   = '0;
            st.count = nb[15:0];
            st.ldStatus = 1'b1; st.ldReason = 1'b1;
            if (nb == '0) begin
              st.status = StReady; st.reason = IrIo | IrCmdData;
              stateN    = S_IDLE;
            end else begin
              st.status = StDrq | StServ; st.reason = IrIo;
              stateN    = S_XFER;
            end
          end
        end
        S_XFER, S_IDENT: if (dataRd && (left != '0)) begin
          rdPtrN = rdPtr + 1'b1;
          if (left <= LenW'(2)) begin
            st.raiseIrq = 1'b1;
            st.ldStatus = 1'b1; st.ldReason = 1'b1; st.reason = IrIo;
            if (remain != '0) begin
              nb       = capLen(remain);
              leftN    = nb;
              remainN  = remain - nb;
              st.ldCount = 1'b1; st.count = nb[15:0];
              st.status  = StDrq | StServ;
            end else begin
              leftN     = '0;
              st.status = 8'h00;
              stateN    = S_IDLE;
            end
          end else begin
            leftN = left - LenW'(2);
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (left == '0)             src = SRC_NONE;
    else if (state == S_XFER)   src = SRC_BUF;
    else if (state == S_IDENT)  src = SRC_IDENT;
    else                        src = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      pktCnt <= '0;
      left   <= '0;
      remain <= '0;
      rdPtr  <= '0;
    end else begin
      state  <= stateN;
      pktCnt <= pktCntN;
      left   <= leftN;
      remain <= remainN;
      rdPtr  <= rdPtrN;
    end
  end
endmodule

// File: rtl/tf_datapath.sv
module tf_datapath
  import tf_pkg::*;
#(
  parameter int BufWords = 64,
  parameter int AddrW    = 6,
  parameter int PtrW     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [2:0]       regIdx,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  input  logic [15:0]      dataWdata,
  output logic [15:0]      dataRdata,
  input  logic             beWrEn,
  input  logic [AddrW-1:0] beWrAddr,
  input  logic [15:0]      beWrData,
  input  strobe_t          st,
  input  src_e             src,
  input  logic [PtrW-1:0]  rdPtr,
  output logic             irq,
  output logic             pktValid,
  output logic [95:0]      pktBytes
);
  logic [7:0]  errQ, reasonQ, tagQ, cntLoQ, cntHiQ, driveQ, statusQ;
  logic [15:0] resBuf [BufWords];
  logic        unusedPtrBits;

  assign unusedPtrBits = ^rdPtr;

  function automatic logic [15:0] identWord(input logic [7:0] idx);
    case (idx)
      8'd0:    return 16'h8580;
      8'd49:   return 16'h0600;
      default: return 16'h0000;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (beWrEn) resBuf[beWrAddr] <= beWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errQ <= 8'h01; reasonQ <= 8'h00; tagQ <= 8'h00;
      cntLoQ <= 8'h14; cntHiQ <= 8'hEB; driveQ <= 8'h00; statusQ <= 8'h00;
      irq <= 1'b0; pktValid <= 1'b0; pktBytes <= '0;
    end else begin
      if (regWr) begin
        case (regIdx)
          IdxErr:    errQ    <= regWdata;
          IdxReason: reasonQ <= regWdata;
          IdxTag:    tagQ    <= regWdata;
          IdxCntLo:  cntLoQ  <= regWdata;
          IdxCntHi:  cntHiQ  <= regWdata;
          IdxDrive:  driveQ  <= regWdata;
          default: ;
        endcase
      end
      if (st.ldStatus) statusQ <= st.status;
      if (st.ldReason) reasonQ <= st.reason;
      if (st.ldErr)    errQ    <= st.err;
      if (st.ldCount) begin
        cntLoQ <= st.count[7:0];
        cntHiQ <= st.count[15:8];
      end
      if (st.raiseIrq)  irq <= 1'b1;
      else if (regRd)   irq <= 1'b0;
      pktValid <= st.pktFire;
      for (int k = 0; k < PktWords; k++) begin
        if (st.pktCapture && (st.pktSlot == 3'(k))) pktBytes[16*k +: 16] <= dataWdata;
      end
    end
  end

  always_comb begin
    case (regIdx)
      IdxData:   regRdata = 8'h00;
      IdxErr:    regRdata = errQ;
      IdxReason: regRdata = reasonQ;
      IdxTag:    regRdata = tagQ;
      IdxCntLo:  regRdata = cntLoQ;
      IdxCntHi:  regRdata = cntHiQ;
      IdxDrive:  regRdata = driveQ;
      default:   regRdata = statusQ;
    endcase
  end

  always_comb begin
    case (src)
      SRC_BUF:   dataRdata = resBuf[rdPtr[AddrW-1:0]];
      SRC_IDENT: dataRdata = identWord(rdPtr[7:0]);
      default:   dataRdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/pkt_taskfile_ctrl.sv
module pkt_taskfile_ctrl
  import tf_pkg::*;
#(
  parameter int LenW     = 24,
  parameter int MaxBurst = 63488,
  parameter int BufWords = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWr,
  input  logic                        regRd,
  input  logic [2:0]                  regIdx,
  input  logic [7:0]                  regWdata,
  output logic [7:0]                  regRdata,
  input  logic                        dataWr,
  input  logic                        dataRd,
  input  logic [15:0]                 dataWdata,
  output logic [15:0]                 dataRdata,
  output logic                        irq,
  output logic                        pktValid,
  output logic [95:0]                 pktBytes,
  input  logic                        beDone,
  input  logic                        beErr,
  input  logic [LenW-1:0]             beLen,
  input  logic                        beWrEn,
  input  logic [$clog2(BufWords)-1:0] beWrAddr,
  input  logic [15:0]                 beWrData
);
  localparam int AddrW = $clog2(BufWords);
  localparam int PtrW  = 16;

  strobe_t         st;
  src_e            src;
  logic [PtrW-1:0] rdPtr;

  tf_ctrl #(.LenW(LenW), .MaxBurst(MaxBurst), .PtrW(PtrW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regIdx(regIdx), .regWdata(regWdata),
    .dataWr(dataWr), .dataRd(dataRd), .beDone(beDone), .beErr(beErr), .beLen(beLen),
    .st(st), .src(src), .rdPtr(rdPtr)
  );

  tf_datapath #(.BufWords(BufWords), .AddrW(AddrW), .PtrW(PtrW)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regIdx(regIdx),
    .regWdata(regWdata), .regRdata(regRdata), .dataWdata(dataWdata), .dataRdata(dataRdata),
    .beWrEn(beWrEn), .beWrAddr(beWrAddr), .beWrData(beWrData),
    .st(st), .src(src), .rdPtr(rdPtr),
    .irq(irq), .pktValid(pktValid), .pktBytes(pktBytes)
  );
endmodule

// File: rtl/tf_checker.sv
module tf_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWr,
  input logic        regRd,
  input logic [2:0]  regIdx,
  input logic [7:0]  regWdata,
  input logic        dataWr,
  input logic        dataRd,
  input logic        beDone,
  input logic        irq,
  input logic        pktValid,
  input logic [15:0] dataRdata
);
  logic cmdWr;
  assign cmdWr = regWr && (regIdx == 3'd7);

  // R12: a lone register read drops the interrupt
  assert_irq_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && !regWr && !dataWr && !dataRd && !beDone) |=> !irq);

  // R9: plain identify aborts with an interrupt
  assert_abort_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && regWdata == 8'hEC) |=> irq);

  // R3: packet handoff is a single-cycle pulse
  assert_pkt_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |=> !pktValid);

  // R10: feature write leaves nothing to read
  assert_feature_flush_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && regWdata == 8'hEF) |=> (dataRdata == 16'h0000));

  // R11: identify stream opens with its signature word
  assert_ident_head_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && regWdata == 8'hA1) |=> (dataRdata == 16'h8580 && irq));

  // R14: an unknown command raises nothing
  assert_unknown_quiet_R14: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && regWdata == 8'h55 && !irq && !dataRd && !dataWr && !beDone) |=> !irq);
endmodule

bind pkt_taskfile_ctrl tf_checker u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regIdx(regIdx),
  .regWdata(regWdata), .dataWr(dataWr), .dataRd(dataRd), .beDone(beDone),
  .irq(irq), .pktValid(pktValid), .dataRdata(dataRdata)
);

// File: tb/sim_pkt_taskfile_ctrl.sv
module sim_pkt_taskfile_ctrl;
  localparam int LenW = 24;
  localparam int MaxB = 16;
  localparam int BufW = 32;
  localparam int NVec = 7;
  localparam int LenTab [NVec] = '{0, 2, 7, 16, 20, 40, 3};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 0, regRd = 0, dataWr = 0, dataRd = 0, beDone = 0, beErr = 0, beWrEn = 0;
  logic [2:0]  regIdx = 0;
  logic [7:0]  regWdata = 0, regRdata;
  logic [15:0] dataWdata = 0, dataRdata, beWrData = 0;
  logic [LenW-1:0] beLen = 0;
  logic [4:0]  beWrAddr = 0;
  logic irq, pktValid;
  logic [95:0] pktBytes;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pkt_taskfile_ctrl #(.LenW(LenW), .MaxBurst(MaxB), .BufWords(BufW)) u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regIdx(regIdx),
    .regWdata(regWdata), .regRdata(regRdata), .dataWr(dataWr), .dataRd(dataRd),
    .dataWdata(dataWdata), .dataRdata(dataRdata), .irq(irq), .pktValid(pktValid),
    .pktBytes(pktBytes), .beDone(beDone), .beErr(beErr), .beLen(beLen),
    .beWrEn(beWrEn), .beWrAddr(beWrAddr), .beWrData(beWrData)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h0123) ^ 16'hBEEF);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] idx, output logic [7:0] v);
    regIdx = idx; #1; v = regRdata;
  endtask

  task automatic writeReg(input logic [2:0] idx, input logic [7:0] val);
    regIdx = idx; regWdata = val; regWr = 1;
    @(negedge clk); regWr = 0;
  endtask

  task automatic readReg(input logic [2:0] idx, output logic [7:0] v);
    regIdx = idx; regRd = 1; #1; v = regRdata;
    @(negedge clk); regRd = 0;
  endtask

  task automatic dataWrite(input logic [15:0] w);
    dataWdata = w; dataWr = 1;
    @(negedge clk); dataWr = 0;
  endtask

  task automatic dataRead(output logic [15:0] w);
    dataRd = 1; #1; w = dataRdata;
    @(negedge clk); dataRd = 0;
  endtask

  task automatic sendPacket(input int seed);
    logic [95:0] exp;
    logic [7:0] v;
    for (int k = 0; k < 6; k++) begin
      logic [15:0] w;
      w = {8'(seed + 2*k + 1), 8'(seed + 2*k)};
      exp[16*k +: 16] = w;
      dataWrite(w);
      if (k < 5) check("R3 no early pulse", {31'd0, pktValid}, 32'd0);
    end
    check("R3 pktValid", {31'd0, pktValid}, 32'd1);
    check("R3 byte0", {24'd0, pktBytes[7:0]}, {24'd0, 8'(seed)});
    check("R3 bytes11", {24'd0, pktBytes[95:88]}, {24'd0, 8'(seed + 11)});
    check("R3 packet", pktBytes[31:0] ^ pktBytes[95:64], exp[31:0] ^ exp[95:64]);
    @(negedge clk);
    check("R3 pulse width", {31'd0, pktValid}, 32'd0);
    peek(3'd7, v); check("R3 busy", {24'd0, v}, 32'h80);
  endtask

  task automatic backendAnswer(input int len, input logic err);
    beLen = LenW'(len); beErr = err; beDone = 1;
    @(negedge clk); beDone = 0; beErr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    peek(3'd7, v); check("R1 status", {24'd0, v}, 32'h00);
    peek(3'd1, v); check("R1 error", {24'd0, v}, 32'h01);
    peek(3'd4, v); check("R1 cntlo", {24'd0, v}, 32'h14);
    peek(3'd5, v); check("R1 cnthi", {24'd0, v}, 32'hEB);
    check("R1 irq", {31'd0, irq}, 32'd0);

    dataRead(w); check("R13 idle read", {16'd0, w}, 32'h0);
    peek(3'd7, v); check("R13 status kept", {24'd0, v}, 32'h00);
    peek(3'd4, v); check("R13 count kept", {24'd0, v}, 32'h14);

    writeReg(3'd7, 8'h55);
    peek(3'd7, v); check("R14 status", {24'd0, v}, 32'h00);
    peek(3'd1, v); check("R14 error", {24'd0, v}, 32'h01);
    peek(3'd5, v); check("R14 cnthi", {24'd0, v}, 32'hEB);
    check("R14 irq", {31'd0, irq}, 32'd0);

    for (int a = 0; a < BufW; a++) begin
      beWrAddr = 5'(a); beWrData = pat(a); beWrEn = 1;
      @(negedge clk);
    end
    beWrEn = 0;

    for (int vi = 0; vi < NVec; vi++) begin
      int len, rem, widx, b;
      len = LenTab[vi];
      writeReg(3'd7, 8'hA0);
      peek(3'd7, v); check("R2 status", {24'd0, v}, 32'h08);
      peek(3'd2, v); check("R2 reason", {24'd0, v}, 32'h01);
      check("R2 irq", {31'd0, irq}, 32'd0);
      sendPacket(vi * 16 + 3);
      backendAnswer(len, 1'b0);
      check("R4/R5 irq", {31'd0, irq}, 32'd1);
      if (len == 0) begin
        peek(3'd7, v); check("R4 status", {24'd0, v}, 32'h40);
        peek(3'd2, v); check("R4 reason", {24'd0, v}, 32'h03);
        peek(3'd4, v); check("R4 cntlo", {24'd0, v}, 32'h00);
        peek(3'd5, v); check("R4 cnthi", {24'd0, v}, 32'h00);
      end
      rem = len; widx = 0;
      while (rem > 0) begin
        b = (rem > MaxB) ? MaxB : rem;
        peek(3'd7, v); check("R5/R6 status", {24'd0, v}, 32'h18);
        peek(3'd2, v); check("R5/R6 reason", {24'd0, v}, 32'h02);
        peek(3'd4, v); check("R5/R6 cntlo", {24'd0, v}, 32'(b & 255));
        peek(3'd5, v); check("R5/R6 cnthi", {24'd0, v}, 32'(b >> 8));
        check("R6 irq per burst", {31'd0, irq}, 32'd1);
        readReg(3'd2, v);
        check("R12 irq cleared", {31'd0, irq}, 32'd0);
        for (int r = 0; r < (b + 1) / 2; r++) begin
          dataRead(w);
          check("R5 data word", {16'd0, w}, {16'd0, pat(widx % BufW)});
          widx++;
        end
        rem -= b;
      end
      if (len > 0) begin
        peek(3'd7, v); check("R7 status", {24'd0, v}, 32'h00);
        peek(3'd2, v); check("R7 reason", {24'd0, v}, 32'h02);
        check("R7 irq", {31'd0, irq}, 32'd1);
      end
      readReg(3'd0, v);
      check("R12 data-index read clears", {31'd0, irq}, 32'd0);
    end

    writeReg(3'd7, 8'hA0);
    sendPacket(200);
    backendAnswer(24, 1'b1);
    peek(3'd7, v); check("R8 status", {24'd0, v}, 32'h09);
    peek(3'd1, v); check("R8 error", {24'd0, v}, 32'h50);
    peek(3'd4, v); check("R8 cntlo", {24'd0, v}, 32'h00);
    peek(3'd5, v); check("R8 cnthi", {24'd0, v}, 32'h00);
    check("R8 irq", {31'd0, irq}, 32'd1);
    readReg(3'd7, v);

    writeReg(3'd7, 8'hEC);
    peek(3'd1, v); check("R9 error", {24'd0, v}, 32'h04);
    peek(3'd7, v); check("R9 status", {24'd0, v}, 32'h01);
    check("R9 irq", {31'd0, irq}, 32'd1);
    readReg(3'd7, v);

    writeReg(3'd7, 8'hA1);
    peek(3'd4, v); check("R11 cntlo", {24'd0, v}, 32'h00);
    peek(3'd5, v); check("R11 cnthi", {24'd0, v}, 32'h02);
    peek(3'd7, v); check("R11 status", {24'd0, v}, 32'h08);
    check("R11 irq", {31'd0, irq}, 32'd1);
    readReg(3'd7, v);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 256; i++) begin
        logic [15:0] e;
        dataRead(w);
        e = (i == 0) ? 16'h8580 : (i == 49) ? 16'h0600 : 16'h0000;
        if (i == 0)  check("R11 word0", {16'd0, w}, 32'h8580);
        if (i == 49) check("R11 word49", {16'd0, w}, 32'h0600);
        if (w !== e) bad++;
      end
      check("R11 all words", 32'(bad), 32'd0);
    end
    peek(3'd7, v); check("R7 identify end status", {24'd0, v}, 32'h00);
    check("R7 identify end irq", {31'd0, irq}, 32'd1);
    readReg(3'd7, v);

    writeReg(3'd7, 8'hA1);
    readReg(3'd7, v);
    dataRead(w); check("R11 restart word0", {16'd0, w}, 32'h8580);
    writeReg(3'd7, 8'hEF);
    peek(3'd7, v); check("R10 status", {24'd0, v}, 32'h00);
    check("R10 irq", {31'd0, irq}, 32'd1);
    dataRead(w); check("R10 discarded", {16'd0, w}, 32'h0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule